// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block sits between a transaction layer and the serial line of an auxiliary display channel. On the request side it takes one transaction description (native or I2C-over-AUX, read/write/write-status-update, middle-of-transaction flag, a 20-bit address, a length of 0 to `MAX_LEN` and the write payload). It turns that description into a header of three or four bytes, adds payload bytes when the transaction is a write, and streams the message out one byte at a time on a valid/ready handshake. The byte count is given before the first byte leaves.

On the reply side it collects a received byte stream that ends with an end strobe. It takes the reply code from the upper nibble of the first byte and checks the amount of returned data against the size the caller asked for. It then presents the code, the data count, the data bytes and error flags for one cycle, marked by a done pulse. Line coding and electrical signalling belong to other blocks.

Top module: `aux_msg_framer`

## Requirements
- R1: Message byte 0 is {command[3:0], addr[19:16]}, byte 1 is addr[15:8] and byte 2 is addr[7:0].
- R2: When the request length is nonzero, byte 3 carries length minus 1. With length zero no such byte is sent.
- R3: `tx_count` equals 3 for length zero and 4 otherwise, plus the length for data-carrying writes. It is valid from the first `tx_valid` cycle. Exactly `tx_count` bytes are transferred, and `tx_last` marks the final one.
- R4: Payload bytes follow the header only for a native write or an I2C write (with or without MOT). Payload byte k is `req_data[8k+7:8k]`. Reads and write-status-update requests send the header alone.
- R5: Command nibble: bit 3 is 1 for native and 0 for I2C. Bit 2 is MOT for I2C and 0 for native. Bits 1:0 are 00 write, 01 read, 10 write-status-update. For I2C, write-status-update takes priority over write, and write over read. For native, `req_wsu` and `req_mot` are ignored.
- R6: `req_ready` is low while a message is in flight. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte` and `tx_last` hold.
- R7: `rep_done` pulses in the cycle after `rx_end`. `rep_code` is bits 7:4 of the first received byte, and 0 means ACK.
- R8: A reply of zero bytes raises `err_invalid`, with `rep_code` and `rep_count` 0.
- R9: Otherwise the data count is the byte count minus 1. On ACK the data bytes appear in order in `rep_data`, and unused bytes are zero. On a non-ACK code, `rep_count` is the data count clamped to `MAX_LEN` and `rep_data` is all zero.
- R10: On ACK with a data count greater than `rep_size`, `err_overflow` is raised and `rep_count` and `rep_data` are zero.
- R11: If `rx_hpd_lost` is high in any cycle since the previous reply ended, up to and including the `rx_end` cycle, only `err_hpd` is raised, with code and count 0. At most one error flag is ever set.
- R12: After reset `req_ready` is 1, and `tx_valid`, `rep_done` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Framer idle, request accepted when both high |
| req_i2c | input | 1 | 1 = I2C-over-AUX, 0 = native |
| req_write | input | 1 | Write transaction |
| req_wsu | input | 1 | I2C write-status-update |
| req_mot | input | 1 | I2C middle-of-transaction |
| req_addr | input | 20 | Transaction address |
| req_len | input | LW | Length 0..MAX_LEN |
| req_data | input | 8*MAX_LEN | Write payload, byte k at bits 8k+7:8k |
| tx_valid | output | 1 | Message byte valid |
| tx_ready | input | 1 | Sink takes the byte |
| tx_byte | output | 8 | Message byte |
| tx_last | output | 1 | Final byte of the message |
| tx_count | output | CW | Total message bytes |
| rx_valid | input | 1 | Received reply byte strobe (low when rx_end is high) |
| rx_byte | input | 8 | Received reply byte |
| rx_end | input | 1 | End of reply |
| rx_hpd_lost | input | 1 | Sink disconnect seen |
| rep_size | input | LW | Requested size to check the reply against |
| rep_done | output | 1 | Reply results valid (one cycle) |
| rep_code | output | 4 | Reply code |
| rep_count | output | LW | Delivered data count |
| rep_data | output | 8*MAX_LEN | Reply data, byte k at bits 8k+7:8k |
| err_invalid | output | 1 | Empty reply |
| err_overflow | output | 1 | ACK data exceeds requested size |
| err_hpd | output | 1 | Disconnect during reply |

## Verification
The request side is swept over all sixteen combinations of type, write, write-status-update and MOT, at every length from 0 to the maximum. Some runs hold `tx_ready` high and others stall it periodically. This separates command-nibble priority errors, a missing or spurious length byte, and payload sent for the wrong actions. The reply side is swept over byte counts from empty to beyond the buffer, over ACK and several non-ACK codes, and over every requested size. This splits the invalid, overflow and clamped-count outcomes. Disconnects are injected at each byte position and at the end strobe, which shows that the abort flag is sticky and that it takes priority.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;
  localparam int ADDR_W  = 20;
  localparam int HDR_MAX = 4;
  localparam logic [1:0] OP_WRITE = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_WSU   = 2'b10;
  localparam logic [3:0] CODE_ACK = 4'h0;
endpackage

// File: rtl/aux_cmd_encode.sv
module aux_cmd_encode
  import aux_frm_pkg::*;
(
  input  logic       i2c_i,
  input  logic       write_i,
  input  logic       wsu_i,
  input  logic       mot_i,
  output logic [3:0] cmd_o,
  output logic       carries_data_o
);
  always_comb begin
    cmd_o          = 4'b0000;
    carries_data_o = 1'b0;
    if (i2c_i) begin
      if (wsu_i) begin
        cmd_o = {1'b0, mot_i, OP_WSU};
      end else if (write_i) begin
        cmd_o          = {1'b0, mot_i, OP_WRITE};
        carries_data_o = 1'b1;
      end else begin
        cmd_o = {1'b0, mot_i, OP_READ};
      end
    end else begin
      if (write_i) begin
        cmd_o          = {2'b10, OP_WRITE};
        carries_data_o = 1'b1;
      end else begin
        cmd_o = {2'b10, OP_READ};
      end
    end
  end
endmodule

// File: rtl/aux_req_builder.sv
module aux_req_builder
  import aux_frm_pkg::*;
#(
  parameter  int MAX_LEN = 16,
  localparam int LW      = $clog2(MAX_LEN + 1),
  localparam int BUFN    = HDR_MAX + MAX_LEN,
  localparam int CW      = $clog2(BUFN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           cmd_i,
  input  logic                 carries_data_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [LW-1:0]        len_i,
  input  logic [8*MAX_LEN-1:0] data_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  output logic                 tx_valid_o,
  input  logic                 tx_ready_i,
  output logic [7:0]           tx_byte_o,
  output logic                 tx_last_o,
  output logic [CW-1:0]        tx_count_o
);
  logic [7:0]    msg_q [BUFN];
  logic [CW-1:0] idx_q;
  logic [CW-1:0] cnt_n;
  logic [CW-1:0] idx_nx;
  logic          accept;
  logic          advance;

  assign accept  = req_valid_i && req_ready_o;
  assign advance = tx_valid_o && tx_ready_i;
  assign idx_nx  = idx_q + CW'(1);

  always_comb begin
    cnt_n = (len_i != '0) ? CW'(4) : CW'(3);
    if (carries_data_i) cnt_n = cnt_n + CW'(len_i);
  end

  // message buffer, no reset so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (accept) begin
      msg_q[0] <= {cmd_i, addr_i[19:16]};
      msg_q[1] <= addr_i[15:8];
      msg_q[2] <= addr_i[7:0];
      msg_q[3] <= 8'(len_i) - 8'd1;
      for (int k = 0; k < MAX_LEN; k++) begin
        msg_q[HDR_MAX + k] <= data_i[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready_o <= 1'b1;
      tx_valid_o  <= 1'b0;
      tx_byte_o   <= 8'h00;
      tx_last_o   <= 1'b0;
      tx_count_o  <= '0;
      idx_q       <= '0;
    end else if (accept) begin
      req_ready_o <= 1'b0;
      tx_valid_o  <= 1'b1;
      tx_byte_o   <= {cmd_i, addr_i[19:16]};
      tx_last_o   <= 1'b0;
      tx_count_o  <= cnt_n;
      idx_q       <= '0;
    end else if (advance) begin
      if (tx_last_o) begin
        tx_valid_o  <= 1'b0;
        tx_last_o   <= 1'b0;
        req_ready_o <= 1'b1;
      end else begin
        idx_q     <= idx_nx;
        tx_byte_o <= msg_q[idx_nx];
        tx_last_o <= (idx_nx + CW'(1)) == tx_count_o;
      end
    end
  end
endmodule

// File: rtl/aux_rep_parser.sv
module aux_rep_parser
  import aux_frm_pkg::*;
#(
  parameter  int MAX_LEN = 16,
  localparam int LW      = $clog2(MAX_LEN + 1),
  localparam int AW      = $clog2(MAX_LEN),
  localparam int RCW     = $clog2(MAX_LEN + 2) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid_i,
  input  logic [7:0]           rx_byte_i,
  input  logic                 rx_end_i,
  input  logic                 rx_hpd_lost_i,
  input  logic [LW-1:0]        size_i,
  output logic                 done_o,
  output logic [3:0]           code_o,
  output logic [LW-1:0]        count_o,
  output logic [8*MAX_LEN-1:0] data_o,
  output logic                 err_invalid_o,
  output logic                 err_overflow_o,
  output logic                 err_hpd_o
);
  logic [7:0]     rbuf_q [MAX_LEN];
  logic [RCW-1:0] nb_q;
  logic [3:0]     code_q;
  logic           hpd_q;
  logic [RCW-1:0] dcnt;
  logic           is_ack;
  logic           hpd_now;
  logic           empty;
  logic           ovf;
  logic           data_ok;
  logic [LW-1:0]  clamped;
  logic           take_byte;

  assign take_byte = rx_valid_i && !rx_end_i;
  assign dcnt      = nb_q - RCW'(1);
  assign is_ack    = (code_q == CODE_ACK);
  assign hpd_now   = hpd_q || rx_hpd_lost_i;
  assign empty     = (nb_q == '0);
  assign ovf       = is_ack && (dcnt > RCW'(size_i));
  assign data_ok   = !hpd_now && !empty && is_ack && !ovf;
  assign clamped   = (dcnt > RCW'(MAX_LEN)) ? LW'(MAX_LEN) : LW'(dcnt);

  always_ff @(posedge clk) begin
    if (take_byte && !empty && (dcnt < RCW'(MAX_LEN))) begin
      rbuf_q[dcnt[AW-1:0]] <= rx_byte_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nb_q           <= '0;
      code_q         <= 4'h0;
      hpd_q          <= 1'b0;
      done_o         <= 1'b0;
      code_o         <= 4'h0;
      count_o        <= '0;
      data_o         <= '0;
      err_invalid_o  <= 1'b0;
      err_overflow_o <= 1'b0;
      err_hpd_o      <= 1'b0;
    end else if (rx_end_i) begin
      done_o         <= 1'b1;
      nb_q           <= '0;
      hpd_q          <= 1'b0;
      code_o         <= 4'h0;
      count_o        <= '0;
      err_invalid_o  <= 1'b0;
      err_overflow_o <= 1'b0;
      err_hpd_o      <= 1'b0;
      if (hpd_now) begin
        err_hpd_o <= 1'b1;
      end else if (empty) begin
        err_invalid_o <= 1'b1;
      end else begin
        code_o <= code_q;
        if (ovf)         err_overflow_o <= 1'b1;
        else if (is_ack) count_o <= LW'(dcnt);
        else             count_o <= clamped;
      end
      for (int k = 0; k < MAX_LEN; k++) begin
        data_o[8*k +: 8] <= (data_ok && (RCW'(k) < dcnt)) ? rbuf_q[k] : 8'h00;
      end
    end else begin
      done_o <= 1'b0;
      hpd_q  <= hpd_now;
      if (take_byte) begin
        if (empty) code_q <= rx_byte_i[7:4];
        if (nb_q != {RCW{1'b1}}) nb_q <= nb_q + RCW'(1);
      end
    end
  end
endmodule

// File: rtl/aux_msg_framer.sv
module aux_msg_framer
  import aux_frm_pkg::*;
#(
  parameter  int MAX_LEN = 16,
  localparam int LW      = $clog2(MAX_LEN + 1),
  localparam int CW      = $clog2(HDR_MAX + MAX_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_i2c,
  input  logic                 req_write,
  input  logic                 req_wsu,
  input  logic                 req_mot,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LW-1:0]        req_len,
  input  logic [8*MAX_LEN-1:0] req_data,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [7:0]           tx_byte,
  output logic                 tx_last,
  output logic [CW-1:0]        tx_count,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_byte,
  input  logic                 rx_end,
  input  logic                 rx_hpd_lost,
  input  logic [LW-1:0]        rep_size,
  output logic                 rep_done,
  output logic [3:0]           rep_code,
  output logic [LW-1:0]        rep_count,
  output logic [8*MAX_LEN-1:0] rep_data,
  output logic                 err_invalid,
  output logic                 err_overflow,
  output logic                 err_hpd
);
  logic [3:0] cmd;
  logic       carries_data;

  aux_cmd_encode enc_i (
    .i2c_i          (req_i2c),
    .write_i        (req_write),
    .wsu_i          (req_wsu),
    .mot_i          (req_mot),
    .cmd_o          (cmd),
    .carries_data_o (carries_data)
  );

  aux_req_builder #(.MAX_LEN(MAX_LEN)) bld_i (
    .clk            (clk),
    .rst            (rst),
    .cmd_i          (cmd),
    .carries_data_i (carries_data),
    .addr_i         (req_addr),
    .len_i          (req_len),
    .data_i         (req_data),
    .req_valid_i    (req_valid),
    .req_ready_o    (req_ready),
    .tx_valid_o     (tx_valid),
    .tx_ready_i     (tx_ready),
    .tx_byte_o      (tx_byte),
    .tx_last_o      (tx_last),
    .tx_count_o     (tx_count)
  );

  aux_rep_parser #(.MAX_LEN(MAX_LEN)) prs_i (
    .clk            (clk),
    .rst            (rst),
    .rx_valid_i     (rx_valid),
    .rx_byte_i      (rx_byte),
    .rx_end_i       (rx_end),
    .rx_hpd_lost_i  (rx_hpd_lost),
    .size_i         (rep_size),
    .done_o         (rep_done),
    .code_o         (rep_code),
    .count_o        (rep_count),
    .data_o         (rep_data),
    .err_invalid_o  (err_invalid),
    .err_overflow_o (err_overflow),
    .err_hpd_o      (err_hpd)
  );
endmodule

// File: rtl/aux_msg_framer_chk.sv
module aux_msg_framer_chk #(
  parameter  int MAX_LEN = 16,
  localparam int LW      = $clog2(MAX_LEN + 1),
  localparam int CW      = $clog2(4 + MAX_LEN + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [LW-1:0]        req_len,
  input logic                 tx_valid,
  input logic                 tx_ready,
  input logic [7:0]           tx_byte,
  input logic                 tx_last,
  input logic [CW-1:0]        tx_count,
  input logic                 rx_end,
  input logic                 rep_done,
  input logic [LW-1:0]        rep_count,
  input logic [3:0]           rep_code,
  input logic                 err_invalid,
  input logic                 err_overflow,
  input logic                 err_hpd
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last)); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !req_ready); // R6
  AST_SHORT_HEADER: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_len == '0) |=> tx_count == CW'(3)); // R3
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    rep_done |-> $past(rx_end)); // R7
  AST_SINGLE_ERROR: assert property (@(posedge clk) disable iff (rst)
    rep_done |-> $countones({err_invalid, err_overflow, err_hpd}) <= 1); // R11
  AST_HPD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rep_done && err_hpd |-> (rep_count == '0) && (rep_code == 4'h0)); // R11
  AST_INVALID_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rep_done && err_invalid |-> rep_count == '0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    rep_done && err_overflow |-> (rep_count == '0) && (rep_code == 4'h0)); // R10
endmodule

bind aux_msg_framer aux_msg_framer_chk #(.MAX_LEN(MAX_LEN)) chk_i (.*);

// File: tb/aux_msg_framer_tb_top.sv
module aux_msg_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 4;
  localparam int LW = $clog2(MAXL + 1);
  localparam int CW = $clog2(4 + MAXL + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_i2c = 0, req_write = 0, req_wsu = 0, req_mot = 0;
  logic [19:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [8*MAXL-1:0] req_data = '0;
  logic req_ready, tx_valid, tx_last;
  logic tx_ready = 0;
  logic [7:0] tx_byte;
  logic [CW-1:0] tx_count;
  logic rx_valid = 0, rx_end = 0, rx_hpd_lost = 0;
  logic [7:0] rx_byte = '0;
  logic [LW-1:0] rep_size = '0;
  logic rep_done, err_invalid, err_overflow, err_hpd;
  logic [3:0] rep_code;
  logic [LW-1:0] rep_count;
  logic [8*MAXL-1:0] rep_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_msg_framer #(.MAX_LEN(MAXL)) dut_i (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] exp_cmd(bit i2c, bit wr, bit wsu, bit mot);
    if (!i2c) return wr ? 4'b1000 : 4'b1001;
    if (wsu) return {1'b0, mot, 2'b10};
    if (wr) return {1'b0, mot, 2'b00};
    return {1'b0, mot, 2'b01};
  endfunction

  task automatic run_req(bit i2c, bit wr, bit wsu, bit mot, int len, int seed, bit stall);
    logic [7:0] exp [0:15];
    int n;
    int got;
    int guard;
    bit data_on;
    logic [19:0] a;
    a = 20'hA5C3E ^ 20'(seed * 4951);
    data_on = wr && !(i2c && wsu);
    for (int k = 0; k < MAXL; k++) req_data[8*k +: 8] = 8'((seed * 37 + k * 11 + 5) & 255);
    exp[0] = {exp_cmd(i2c, wr, wsu, mot), a[19:16]};
    exp[1] = a[15:8];
    exp[2] = a[7:0];
    n = 3;
    if (len != 0) begin
      exp[3] = 8'(len - 1);
      n = 4;
    end
    if (data_on) for (int k = 0; k < len; k++) exp[n + k] = req_data[8*k +: 8];
    if (data_on) n = n + len;
    guard = 0;
    while (!req_ready && guard < 50) begin step(); guard++; end
    req_i2c = i2c; req_write = wr; req_wsu = wsu; req_mot = mot;
    req_addr = a; req_len = LW'(len); req_valid = 1;
    step();
    req_valid = 0;
    check("R3 tx_count", 64'(tx_count), 64'(n));
    check("R6 req_ready low while busy", 64'(req_ready), 64'd0);
    got = 0;
    guard = 0;
    while (got < n && guard < 100) begin
      tx_ready = stall ? ((guard % 3) != 1) : 1'b1;
      if (tx_valid && tx_ready) begin
        if (got < 3) check("R1 R5 header byte", 64'(tx_byte), 64'(exp[got]));
        else if (got == 3 && len != 0) check("R2 length byte", 64'(tx_byte), 64'(exp[got]));
        else check("R4 payload byte", 64'(tx_byte), 64'(exp[got]));
        check("R3 tx_last position", 64'(tx_last), 64'(got == n - 1));
        got++;
      end
      step();
      guard++;
    end
    tx_ready = 0;
    check("R3 byte total", 64'(got), 64'(n));
    check("R3 stream ends", 64'(tx_valid), 64'd0);
  endtask

  task automatic run_rep(int n, logic [3:0] code, int size, int hpd_at);
    logic [7:0] b [0:15];
    logic [3:0] ecode;
    int ecount;
    logic [8*MAXL-1:0] edata;
    logic [2:0] eflags;
    b[0] = {code, 4'h5};
    for (int k = 1; k < 16; k++) b[k] = 8'((k * 29 + int'(code)) & 255);
    rep_size = LW'(size);
    for (int k = 0; k < n; k++) begin
      rx_valid = 1; rx_byte = b[k]; rx_hpd_lost = (hpd_at == k);
      step();
    end
    rx_valid = 0; rx_hpd_lost = (hpd_at == n); rx_end = 1;
    step();
    rx_end = 0; rx_hpd_lost = 0;
    edata = '0; ecode = 4'h0; ecount = 0; eflags = 3'b000;
    if (hpd_at >= 0 && hpd_at <= n) eflags = 3'b001;
    else if (n == 0) eflags = 3'b100;
    else begin
      ecode = code;
      if (code == 0 && n - 1 > size) eflags = 3'b010;
      else if (code == 0) begin
        ecount = n - 1;
        for (int k = 0; k < ecount; k++) edata[8*k +: 8] = b[k + 1];
      end else ecount = (n - 1 > MAXL) ? MAXL : n - 1;
    end
    check("R7 rep_done", 64'(rep_done), 64'd1);
    check("R7 rep_code", 64'(rep_code), 64'(ecode));
    check("R9 rep_count", 64'(rep_count), 64'(ecount));
    check("R9 R10 rep_data", 64'(rep_data), 64'(edata));
    check("R8 R10 R11 error flags", 64'({err_invalid, err_overflow, err_hpd}), 64'(eflags));
    step();
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    #1;
    check("R12 req_ready after reset", 64'(req_ready), 64'd1);
    check("R12 tx_valid after reset", 64'(tx_valid), 64'd0);
    check("R12 rep_done after reset", 64'(rep_done), 64'd0);
    check("R12 flags after reset", 64'({err_invalid, err_overflow, err_hpd}), 64'd0);
    for (int f = 0; f < 16; f++)
      for (int l = 0; l <= MAXL; l++)
        run_req(f[3], f[2], f[1], f[0], l, f * 8 + l, (f + l) % 2 == 1);
    for (int n = 0; n <= MAXL + 3; n++)
      for (int c = 0; c < 5; c++)
        for (int s = 0; s <= MAXL; s++)
          run_rep(n, (c == 0) ? 4'h0 : 4'(1 << (c - 1)), s, -1);
    for (int p = 0; p <= 3; p++) run_rep(3, 4'h0, MAXL, p);
    run_rep(0, 4'h0, 2, 0);
    run_rep(2, 4'h0, MAXL, -1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule